// File: doc/BRIEF.md
# Derivative-Threshold Pulse Charge and Time Extractor

The block watches a stream of unsigned digitized waveform samples, grouped into records, and picks out one pulse at a time. For each accepted sample it forms the difference from the previous sample of the same record, a discrete first derivative. A hit region opens when that difference rises above a programmable threshold and stays open while it remains above it. The block reports the pulse charge, a coarse time and a fine time. The charge is the sum of the raw samples inside the region, each minus a pedestal. The pedestal is the mean of the eight samples just before the region. The coarse time is the sample index of the region's largest sample. The fine time is a signed sub-sample offset read from a small writable table. The table address comes from the shape of the peak and its two neighbours.

A controller walks three states. SEEK looks for an opening sample and goes to HIT when one arrives (the transition *open*). If the opening sample is also the record's last sample, it goes straight to EMIT (*open-and-truncate*). HIT accumulates samples. It goes to EMIT either when a sample falls to or below the threshold (*close*) or when the record's last sample is still inside the region (*truncate*). EMIT presents the result for one cycle and always returns to SEEK (*report*).

Top module: `pk_pulse_extract`

## Requirements
- R1: After reset `res_valid` is low, the controller is in SEEK, and fine-table entry k holds the value 8 - k (for k = 0..15).
- R2: A region opens only on a sample whose difference from the previous sample is strictly greater than `thr`. A difference equal to `thr` opens nothing. The first sample of a record (`rec_start` high) has difference 0.
- R3: No region opens on a sample whose index in its record is below 8. Index 0 is the sample carrying `rec_start`.
- R4: The pedestal is the floor of the mean of the eight samples that immediately precede the opening sample.
- R5: `res_charge` is the signed sum, over every sample from the opening sample through the last sample whose difference exceeds `thr`, of the sample minus the pedestal.
- R6: `res_coarse` is the record index of the largest sample in the region. On a tie, the earliest such sample is used.
- R7: Let P be the peak value, L the sample before it and R the sample after it. Let a = max(P-L,0), b = max(P-R,0) and s = a+b. The table address is 8 when s = 0. Otherwise it is the number of j in 1..15 with 16*b >= j*s. `res_fine` is the table entry at that address, a signed offset in 1/16-sample units.
- R8: A cycle with `lut_we` high stores `lut_wdata` at table entry `lut_waddr`. Every later result reads the new value.
- R9: `res_valid` is high for exactly one cycle. That cycle comes one clock after the edge that accepts the closing sample.
- R10: If the record's last sample lies inside the region, the region closes at it, R is taken equal to P, and `res_trunc` is 1. If the last sample is itself the closing sample (difference at or below `thr`), `res_trunc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_data | input | 12 | Unsigned sample value |
| rec_start | input | 1 | Sample is the first of a record |
| rec_last | input | 1 | Sample is the last of a record |
| thr | input | 12 | Difference threshold |
| lut_we | input | 1 | Fine-table write strobe |
| lut_waddr | input | 4 | Fine-table write address |
| lut_wdata | input | 5 | Signed fine-table write value |
| res_valid | output | 1 | Result strobe |
| res_charge | output | 24 | Signed pedestal-subtracted charge |
| res_coarse | output | 12 | Record index of the peak sample |
| res_fine | output | 5 | Signed fine offset in 1/16 sample |
| res_trunc | output | 1 | Region was cut off by the record end |

## Verification
The function most easily mishandled is the meeting of the region end and the record end on one sample. In that case a single input decides between a normal close and a truncation. The bench sends three short records. In the first, the last sample still rises above the threshold. In the second, the last sample is the falling sample that closes the region. In the third, the last sample is the one that opens the region. In each case it judges the truncation flag, the mirrored right neighbour as seen in the fine value, the charge, and the exact cycle in which the one-cycle result strobe appears.

// File: rtl/pk_pkg.sv
package pk_pkg;
    typedef enum logic [1:0] {
        PK_SEEK = 2'd0,
        PK_HIT  = 2'd1,
        PK_EMIT = 2'd2
    } pk_state_e;
endpackage

// File: rtl/pk_front.sv
// Sample front end: difference against the previous sample, record index,
// and the rolling pre-hit window with its shift-based mean.
module pk_front #(
    parameter int DW       = 12,
    parameter int IW       = 12,
    parameter int WIN_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DW-1:0]        smp_data,
    input  logic                 rec_start,
    output logic signed [DW:0]   cur_diff,
    output logic [IW-1:0]        cur_idx,
    output logic [DW-1:0]        prev_smp,
    output logic [DW-1:0]        win_mean,
    output logic                 armed
);
    localparam int WIN = 1 << WIN_LOG2;
    localparam int SW  = DW + WIN_LOG2;

    logic [DW-1:0] win_q [WIN];
    logic [DW-1:0] prev_q;
    logic [IW-1:0] idx_q;
    logic [SW-1:0] win_sum;

    always_comb begin
        if (rec_start) begin
            cur_idx  = '0;
            cur_diff = '0;
        end else begin
            cur_idx  = (idx_q == '1) ? idx_q : idx_q + 1'b1;
            cur_diff = $signed({1'b0, smp_data}) - $signed({1'b0, prev_q});
        end
        armed   = (cur_idx >= IW'(WIN));
        win_sum = '0;
        for (int k = 0; k < WIN; k++) begin
            win_sum = win_sum + SW'(win_q[k]);
        end
        win_mean = win_sum[SW-1:WIN_LOG2];
    end

    assign prev_smp = prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            idx_q  <= '0;
            for (int k = 0; k < WIN; k++) begin
                win_q[k] <= '0;
            end
        end else if (smp_valid) begin
            prev_q   <= smp_data;
            idx_q    <= cur_idx;
            win_q[0] <= smp_data;
            for (int k = 1; k < WIN; k++) begin
                win_q[k] <= win_q[k-1];
            end
        end
    end
endmodule

// File: rtl/pk_peak_track.sv
// Charge accumulation and peak/neighbour capture across one hit region.
module pk_peak_track #(
    parameter int DW = 12,
    parameter int IW = 12,
    parameter int CW = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  step,
    input  logic                  close_in,
    input  logic [DW-1:0]         x,
    input  logic [DW-1:0]         prev,
    input  logic [DW-1:0]         ped,
    input  logic [IW-1:0]         idx,
    output logic signed [CW-1:0]  charge,
    output logic [DW-1:0]         pk_val,
    output logic [DW-1:0]         pk_left,
    output logic [DW-1:0]         pk_right,
    output logic [IW-1:0]         pk_idx
);
    logic                 need_r;
    logic signed [DW:0]   net;
    logic signed [CW-1:0] net_ext;

    assign net     = $signed({1'b0, x}) - $signed({1'b0, ped});
    assign net_ext = {{(CW-DW-1){net[DW]}}, net};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            charge   <= '0;
            pk_val   <= '0;
            pk_left  <= '0;
            pk_right <= '0;
            pk_idx   <= '0;
            need_r   <= 1'b0;
        end else if (init) begin
            // right neighbour defaults to the peak itself (mirror)
            charge   <= net_ext;
            pk_val   <= x;
            pk_left  <= prev;
            pk_right <= x;
            pk_idx   <= idx;
            need_r   <= 1'b1;
        end else if (step) begin
            charge <= charge + net_ext;
            if (x > pk_val) begin
                pk_val   <= x;
                pk_left  <= prev;
                pk_right <= x;
                pk_idx   <= idx;
                need_r   <= 1'b1;
            end else if (need_r) begin
                pk_right <= x;
                need_r   <= 1'b0;
            end
        end else if (close_in && need_r) begin
            pk_right <= x;
            need_r   <= 1'b0;
        end
    end
endmodule

// File: rtl/pk_fine_lut.sv
// Quantized neighbour-difference ratio and the writable fine-offset table.
module pk_fine_lut #(
    parameter int DW = 12,
    parameter int QB = 4,
    parameter int FW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lut_we,
    input  logic [QB-1:0]        lut_waddr,
    input  logic signed [FW-1:0] lut_wdata,
    input  logic [DW-1:0]        pk_val,
    input  logic [DW-1:0]        pk_left,
    input  logic [DW-1:0]        pk_right,
    output logic signed [FW-1:0] fine
);
    localparam int Q  = 1 << QB;
    localparam int AW = DW + QB + 2;

    logic [DW-1:0]        rise_a;
    logic [DW-1:0]        fall_b;
    logic [AW-1:0]        sum_w;
    logic [AW-1:0]        fall_w;
    logic [Q-1:0]         ge;
    logic [QB:0]          cnt;
    logic [QB-1:0]        addr;
    logic signed [FW-1:0] tab_q [Q];

    assign rise_a = (pk_val > pk_left)  ? pk_val - pk_left  : '0;
    assign fall_b = (pk_val > pk_right) ? pk_val - pk_right : '0;
    assign sum_w  = AW'(rise_a) + AW'(fall_b);
    assign fall_w = AW'(fall_b) << QB;
    assign ge[0]  = 1'b0;

    generate
        for (genvar j = 1; j < Q; j++) begin : g_cmp
            assign ge[j] = (fall_w >= sum_w * AW'(j));
        end
    endgenerate

    always_comb begin
        cnt = '0;
        for (int k = 0; k < Q; k++) begin
            cnt = cnt + (QB+1)'(ge[k]);
        end
        addr = (sum_w == '0) ? QB'(Q/2) : cnt[QB-1:0];
        fine = tab_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < Q; k++) begin
                tab_q[k] <= FW'(Q/2 - k);
            end
        end else if (lut_we) begin
            tab_q[lut_waddr] <= lut_wdata;
        end
    end
endmodule

// File: rtl/pk_pulse_extract.sv
module pk_pulse_extract
    import pk_pkg::*;
#(
    parameter int DW = 12,
    parameter int IW = 12,
    parameter int CW = 24,
    parameter int QB = 4,
    parameter int FW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DW-1:0]        smp_data,
    input  logic                 rec_start,
    input  logic                 rec_last,
    input  logic [DW-1:0]        thr,
    input  logic                 lut_we,
    input  logic [QB-1:0]        lut_waddr,
    input  logic signed [FW-1:0] lut_wdata,
    output logic                 res_valid,
    output logic signed [CW-1:0] res_charge,
    output logic [IW-1:0]        res_coarse,
    output logic signed [FW-1:0] res_fine,
    output logic                 res_trunc
);
    pk_state_e            state_q, state_d;
    logic signed [DW:0]   cur_diff;
    logic [IW-1:0]        cur_idx;
    logic [DW-1:0]        prev_smp, win_mean, ped_q;
    logic                 armed, over, open_ev, step_ev, close_ev, trunc_q;
    logic signed [CW-1:0] charge;
    logic [DW-1:0]        pk_val, pk_left, pk_right;
    logic [IW-1:0]        pk_idx;
    logic signed [FW-1:0] fine;
    logic [DW-1:0]        ped_now;

    pk_front #(.DW(DW), .IW(IW), .WIN_LOG2(3)) front_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rec_start(rec_start), .cur_diff(cur_diff), .cur_idx(cur_idx),
        .prev_smp(prev_smp), .win_mean(win_mean), .armed(armed)
    );

    assign over     = cur_diff > $signed({1'b0, thr});
    assign open_ev  = smp_valid && (state_q == PK_SEEK) && armed && over;
    assign step_ev  = smp_valid && (state_q == PK_HIT) && over;
    assign close_ev = smp_valid && (state_q == PK_HIT) && !over;
    assign ped_now  = open_ev ? win_mean : ped_q;

    pk_peak_track #(.DW(DW), .IW(IW), .CW(CW)) track_i (
        .clk(clk), .rst_n(rst_n), .init(open_ev), .step(step_ev),
        .close_in(close_ev), .x(smp_data), .prev(prev_smp), .ped(ped_now),
        .idx(cur_idx), .charge(charge), .pk_val(pk_val), .pk_left(pk_left),
        .pk_right(pk_right), .pk_idx(pk_idx)
    );

    pk_fine_lut #(.DW(DW), .QB(QB), .FW(FW)) lut_i (
        .clk(clk), .rst_n(rst_n), .lut_we(lut_we), .lut_waddr(lut_waddr),
        .lut_wdata(lut_wdata), .pk_val(pk_val), .pk_left(pk_left),
        .pk_right(pk_right), .fine(fine)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_SEEK: if (open_ev) state_d = rec_last ? PK_EMIT : PK_HIT;
            PK_HIT:  if (close_ev || (step_ev && rec_last)) state_d = PK_EMIT;
            PK_EMIT: state_d = PK_SEEK;
            default: state_d = PK_SEEK;
        endcase
    end

    // state register and region context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PK_SEEK;
            ped_q   <= '0;
            trunc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (open_ev) begin
                ped_q   <= win_mean;
                trunc_q <= rec_last;
            end else if (step_ev) begin
                trunc_q <= rec_last;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_charge <= '0;
            res_coarse <= '0;
            res_fine   <= '0;
            res_trunc  <= 1'b0;
        end else begin
            res_valid <= (state_q == PK_EMIT);
            if (state_q == PK_EMIT) begin
                res_charge <= charge;
                res_coarse <= pk_idx;
                res_fine   <= fine;
                res_trunc  <= trunc_q;
            end
        end
    end
endmodule

// File: rtl/pk_pulse_extract_chk.sv
module pk_pulse_extract_chk
    import pk_pkg::*;
#(
    parameter int DW  = 12,
    parameter int IW  = 12,
    parameter int WIN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input pk_state_e          state_q,
    input logic               open_ev,
    input logic [IW-1:0]      cur_idx,
    input logic signed [DW:0] cur_diff,
    input logic [DW-1:0]      thr,
    input logic               res_valid
);
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_strobe_after_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(state_q) == PK_EMIT);

    p_emit_to_seek_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PK_EMIT |=> state_q == PK_SEEK);

    p_open_window_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        open_ev |-> cur_idx >= IW'(WIN));

    p_open_above_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        open_ev |-> cur_diff > $signed({1'b0, thr}));
endmodule

bind pk_pulse_extract pk_pulse_extract_chk #(.DW(DW), .IW(IW), .WIN(8)) chk_i (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .open_ev(open_ev),
    .cur_idx(cur_idx), .cur_diff(cur_diff), .thr(thr), .res_valid(res_valid)
);

// File: tb/pk_pulse_extract_tb_top.sv
module pk_pulse_extract_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic [11:0]        smp_data = '0;
    logic               rec_start = 1'b0;
    logic               rec_last = 1'b0;
    logic [11:0]        thr = '0;
    logic               lut_we = 1'b0;
    logic [3:0]         lut_waddr = '0;
    logic signed [4:0]  lut_wdata = '0;
    logic               res_valid;
    logic signed [23:0] res_charge;
    logic [11:0]        res_coarse;
    logic signed [4:0]  res_fine;
    logic               res_trunc;

    int n_chk = 0, n_fail = 0, nres = 0;
    int cap_charge = 0, cap_coarse = 0, cap_fine = 0, cap_trunc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pk_pulse_extract dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rec_start(rec_start), .rec_last(rec_last), .thr(thr), .lut_we(lut_we),
        .lut_waddr(lut_waddr), .lut_wdata(lut_wdata), .res_valid(res_valid),
        .res_charge(res_charge), .res_coarse(res_coarse), .res_fine(res_fine),
        .res_trunc(res_trunc)
    );

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            nres       = nres + 1;
            cap_charge = int'(res_charge);
            cap_coarse = int'(res_coarse);
            cap_fine   = int'(res_fine);
            cap_trunc  = int'(res_trunc);
        end
    end

    typedef struct packed {
        int base; int alt; int step; int len; int pos; int th; int post;
        int hit; int charge; int coarse; int fine;
    } vec_t;
    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{100,  0, 50, 3,  8, 20, 100,  1, 300,  10, -4},  // R5 R6 R7
        '{200,  0, 30, 1, 10, 10, 200,  1,  30,  10,  0},  // R7 symmetric
        '{50,   1, 40, 2, 12, 20,  50,  1, 120,  13, -2},  // R4 uneven baseline
        '{1000, 0,100, 4,  9, 50,1000,  1,1000,  12, -4},  // R5 R6
        '{100,  0, 20, 3,  8, 20, 100,  0,   0,   0,  0},  // R2 equal to thr
        '{100,  0, 60, 2,  5, 10, 100,  0,   0,   0,  0},  // R3 too early
        '{100,  0, 40, 2,  8, 10, 170,  1, 120,   9,  5},  // R7 R1 entry 3
        '{300,  0, 25, 2,  8, 10, 360,  1,  75,   9,  8}   // R7 clamp, R1 entry 0
    };

    function automatic int smp_of(vec_t v, int i);
        if (i >= v.pos && i < v.pos + v.len) return v.base + v.step * (i - v.pos + 1);
        if (i == v.pos + v.len) return v.post;
        return v.base + ((v.alt != 0 && (i % 2) == 1) ? 1 : 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(int v, bit st, bit lst);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 12'(v);
        rec_start = st;
        rec_last  = lst;
        @(posedge clk);
    endtask

    task automatic stop_stream();
        @(negedge clk);
        smp_valid = 1'b0;
        rec_start = 1'b0;
        rec_last  = 1'b0;
    endtask

    task automatic lut_write(int a, int d);
        @(negedge clk);
        lut_we    = 1'b1;
        lut_waddr = 4'(a);
        lut_wdata = 5'(d);
        @(negedge clk);
        lut_we    = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic run_vec(vec_t v, int fine_exp, string tag);
        int n0;
        n0  = nres;
        thr = 12'(v.th);
        for (int i = 0; i < 20; i++) push(smp_of(v, i), i == 0, i == 19);
        stop_stream();
        repeat (4) @(negedge clk);
        chk({tag, " result count"}, nres - n0, v.hit);
        if (v.hit != 0) begin
            chk({tag, " R5 charge"}, cap_charge, v.charge);
            chk({tag, " R6 coarse"}, cap_coarse, v.coarse);
            chk({tag, " R7 fine"}, cap_fine, fine_exp);
            chk({tag, " R10 trunc"}, cap_trunc, 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res_valid after reset", int'(res_valid), 0);
        chk("R1 charge after reset", int'(res_charge), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 no result after reset", nres, 0);

        for (int e = 0; e < NV; e++) begin
            run_vec(VT[e], VT[e].fine, $sformatf("vec%0d", e));
        end

        // R10 last sample still inside the region
        thr = 12'd10;
        n0 = nres;
        for (int i = 0; i < 9; i++) push(100, i == 0, 1'b0);
        push(140, 0, 0); push(180, 0, 0); push(220, 0, 1);
        stop_stream();
        repeat (3) @(negedge clk);
        chk("R10 trunc count", nres - n0, 1);
        chk("R10 trunc flag", cap_trunc, 1);
        chk("R10 trunc charge R5", cap_charge, 240);
        chk("R10 trunc coarse R6", cap_coarse, 11);
        chk("R10 trunc mirror fine R7", cap_fine, 8);

        // R9 and R10: last sample is the closing sample
        n0 = nres;
        for (int i = 0; i < 9; i++) push(100, i == 0, 1'b0);
        push(140, 0, 0); push(180, 0, 0); push(100, 0, 1);
        stop_stream();
        chk("R9 no strobe in close cycle", int'(res_valid), 0);
        @(negedge clk);
        chk("R9 strobe one cycle after close", int'(res_valid), 1);
        @(negedge clk);
        chk("R9 strobe lasts one cycle", int'(res_valid), 0);
        chk("R9 single result", nres - n0, 1);
        chk("R10 close on last not truncated", cap_trunc, 0);
        chk("R10 close on last charge", cap_charge, 120);
        chk("R10 close on last fine", cap_fine, -2);

        // R10 opening sample is the last sample
        n0 = nres;
        for (int i = 0; i < 10; i++) push(100, i == 0, 1'b0);
        push(150, 0, 1);
        stop_stream();
        repeat (3) @(negedge clk);
        chk("R10 open on last count", nres - n0, 1);
        chk("R10 open on last flag", cap_trunc, 1);
        chk("R10 open on last charge", cap_charge, 50);
        chk("R10 open on last coarse", cap_coarse, 10);

        // R8 table write takes effect
        lut_write(8, -3);
        run_vec(VT[1], -3, "R8 written entry");
        lut_write(8, 0);
        run_vec(VT[1], 0, "R8 restored entry");

        done = 1'b1;
        report();
        $finish;
    end
endmodule